// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches a set of general-purpose input lines that are already synchronous to its clock. For every line it decides whether an interrupt is pending, and it combines all pending, enabled lines into one request for a parent interrupt controller. Each line can be set at run time to sense a level or an edge. Edge sensing can pick one edge, or it can pick both edges, and the both-edges setting then overrides the polarity bit.

A byte-wide register port sets up the block and reads it back. A write lands on the rising clock edge while the write strobe is high. Read data is a combinational function of the address. The raw status register shows every pending line, whether or not it is enabled. The masked status register shows only the enabled ones. Edge events stay latched until software writes a one to the matching bit of the clear register. Level events follow the pin and cannot be cleared by software.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, every configuration register, the enable register and the raw status read 0, and `irq_o` is 0.
- R2: These registers read back the last byte written to them, with bit n belonging to line n: the enable register at 0x410, the sense register at 0x404 (1 = level, 0 = edge), the polarity register at 0x40C (1 = high level or rising edge, 0 = low level or falling edge) and the dual-edge register at 0x408.
- R3: On an edge-sensed line with dual-edge off, the raw status bit (read at 0x414) is set on the first clock edge at which the pin differs from its value at the previous clock edge in the direction the polarity bit selects. An edge in the other direction sets nothing.
- R4: On an edge-sensed line with the dual-edge bit set, a rise and a fall both set the raw status bit, whatever the polarity bit holds.
- R5: A latched edge status stays set after the pin returns to its idle level. It is latched even while the line's enable bit is 0.
- R6: Writing to 0x41C clears the latched edge status of every line whose data bit is 1. Bits written as 0 have no effect. A read of 0x41C returns 0.
- R7: When a clear of a line and a new edge on that same line fall in the same cycle, the edge wins and the status stays 1.
- R8: On a level-sensed line, the raw status bit equals (pin == polarity bit) as sampled at the previous clock edge. A clear write has no effect on it.
- R9: The masked status register at 0x418 reads raw AND enable. Writes to 0x414 and 0x418 change nothing.
- R10: `irq_o` is 1 exactly when at least one masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Synchronised GPIO input lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational on the address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The pins are driven through lone rising pulses, lone falling pulses and slow toggles. These patterns separate rising-edge, falling-edge, dual-edge and level sensing, because only the selected direction may latch. Clears are written alone, written with zero bits, and written in the same cycle as a fresh edge, which tells a plain clear apart from the edge-wins rule. Level lines are held at both the active and the idle value, with and without clear writes, to show that their status tracks the pin and ignores software. Enable patterns that mask some pending lines and expose others separate the raw view from the masked view and from the request output.

// File: rtl/gid_pkg.sv
// Package: shared constants of the GPIO interrupt detector.
// Assumes byte-wide registers and a 12-bit byte address.
package gid_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_DUAL  = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_POL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_EN    = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h41C;
endpackage

// File: rtl/gid_regs.sv
// Module: gid_regs
// Holds the per-line configuration and the enable register. It decodes
// writes, produces a one-cycle clear vector and muxes the read data.
// Assumes that writes are single-cycle strobes and that reads are
// combinational on the address.
module gid_regs
    import gid_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LINES-1:0]  wdata_i,
    input  logic [LINES-1:0]  raw_i,
    output logic [LINES-1:0]  sense_o,
    output logic [LINES-1:0]  dual_o,
    output logic [LINES-1:0]  pol_o,
    output logic [LINES-1:0]  en_o,
    output logic [LINES-1:0]  clr_o,
    output logic [LINES-1:0]  rdata_o
);
    logic [LINES-1:0] sense_q, dual_q, pol_q, en_q;

    // Configuration storage, written on a strobe at the matching address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            dual_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (wr_i) begin
            if (addr_i == OFF_SENSE) sense_q <= wdata_i;
            if (addr_i == OFF_DUAL)  dual_q  <= wdata_i;
            if (addr_i == OFF_POL)   pol_q   <= wdata_i;
            if (addr_i == OFF_EN)    en_q    <= wdata_i;
        end
    end

    // Clear vector: live for the single cycle of a write to the clear address.
    always_comb begin
        clr_o = (wr_i && addr_i == OFF_CLR) ? wdata_i : '0;
    end

    // Read mux; the clear address and unknown addresses read as zero.
    always_comb begin
        case (addr_i)
            OFF_SENSE: rdata_o = sense_q;
            OFF_DUAL:  rdata_o = dual_q;
            OFF_POL:   rdata_o = pol_q;
            OFF_EN:    rdata_o = en_q;
            OFF_RAW:   rdata_o = raw_i;
            OFF_MSK:   rdata_o = raw_i & en_q;
            default:   rdata_o = '0;
        endcase
    end

    assign sense_o = sense_q;
    assign dual_o  = dual_q;
    assign pol_o   = pol_q;
    assign en_o    = en_q;

    // R2: an enable write is visible on the following cycle.
    assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFF_EN) |=> (en_o == $past(wdata_i)));

    // R9: a write to the status addresses leaves the enable untouched.
    assert_status_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == OFF_RAW || addr_i == OFF_MSK)) |=> $stable(en_o));
endmodule

// File: rtl/gid_line.sv
// Module: gid_line
// Detection for one input line. It keeps the previous pin sample, finds
// rising and falling edges, and holds one raw status bit. That bit
// follows the pin in level mode and is latched in edge mode.
// Assumes pin_i is already synchronous to clk and idles low through reset.
module gid_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic sense_i,
    input  logic dual_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic stat_o
);
    logic pin_q;
    logic rise, fall, hit;

    // Previous pin sample, the reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_i;
    end

    // Edge qualification from the polarity and dual-edge settings.
    always_comb begin
        rise = pin_i & ~pin_q;
        fall = ~pin_i & pin_q;
        hit  = dual_i ? (rise | fall) : (pol_i ? rise : fall);
    end

    // Status: track the level, or latch the edge with the edge beating a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_o <= 1'b0;
        else if (sense_i) stat_o <= (pin_i == pol_i);
        else              stat_o <= hit | (stat_o & ~clr_i);
    end

    // R3: a selected rising edge latches.
    assert_rise_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && !dual_i && pol_i && pin_i && !pin_q) |=> stat_o);

    // R4: any change latches in dual-edge mode.
    assert_dual_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && dual_i && (pin_i != pin_q)) |=> stat_o);

    // R6: a clear with no edge in flight empties the status.
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && clr_i && (pin_i == pin_q)) |=> !stat_o);

    // R8: a level line mirrors the pin compared with the polarity.
    assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sense_i |=> (stat_o == $past(pin_i == pol_i)));
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Top of the GPIO interrupt detector: the register block, one detector per
// line and the combined request output.
// Assumes synchronous inputs and a single clock domain.
module gpio_irq_detect
    import gid_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  pin_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [LINES-1:0]  bus_wdata_i,
    output logic [LINES-1:0]  bus_rdata_o,
    output logic              irq_o
);
    logic [LINES-1:0] sense, dual, pol, en, clr, raw;

    gid_regs #(.LINES(LINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .raw_i   (raw),
        .sense_o (sense),
        .dual_o  (dual),
        .pol_o   (pol),
        .en_o    (en),
        .clr_o   (clr),
        .rdata_o (bus_rdata_o)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gid_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[i]),
            .sense_i (sense[i]),
            .dual_i  (dual[i]),
            .pol_i   (pol[i]),
            .clr_i   (clr[i]),
            .stat_o  (raw[i])
        );
    end

    // Combined request: any line both pending and enabled.
    always_comb begin
        irq_o = |(raw & en);
    end

    // R10: a request needs at least one enabled line.
    assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en != '0));
endmodule

// File: tb/sim_gpio_irq_detect.sv
// Bench: a behavioural reference model is updated on every rising edge and
// compared with the design on every falling edge, plus directed reads.
module sim_gpio_irq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = 12'h414;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_detect u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // Reference model state.
    logic [7:0] m_sense, m_dual, m_pol, m_en, m_raw, m_prev;

    always @(posedge clk) begin
        logic [7:0] nraw;
        logic [7:0] clrv;
        if (!rst_n) begin
            m_sense = 0; m_dual = 0; m_pol = 0; m_en = 0; m_raw = 0; m_prev = 0;
        end else begin
            clrv = (wr && addr == 12'h41C) ? wdata : 8'h00;
            nraw = m_raw;
            for (int i = 0; i < 8; i++) begin
                if (m_sense[i]) nraw[i] = (pin[i] == m_pol[i]);
                else begin
                    bit up, dn, ev;
                    up = pin[i] && !m_prev[i];
                    dn = !pin[i] && m_prev[i];
                    ev = m_dual[i] ? (up || dn) : (m_pol[i] ? up : dn);
                    if (clrv[i]) nraw[i] = 1'b0;
                    if (ev) nraw[i] = 1'b1;
                end
            end
            if (wr) begin
                if (addr == 12'h404) m_sense = wdata;
                if (addr == 12'h408) m_dual = wdata;
                if (addr == 12'h40C) m_pol = wdata;
                if (addr == 12'h410) m_en = wdata;
            end
            m_prev = pin;
            m_raw = nraw;
        end
    end

    function automatic logic [7:0] m_read(logic [11:0] a);
        case (a)
            12'h404: return m_sense;
            12'h408: return m_dual;
            12'h40C: return m_pol;
            12'h410: return m_en;
            12'h414: return m_raw;
            12'h418: return m_raw & m_en;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every-clock comparison of the request output and the status views.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R10 irq", {7'b0, irq}, {7'b0, |(m_raw & m_en)});
            if (addr == 12'h414 || addr == 12'h418)
                check("R9 status view", rdata, m_read(addr));
        end
    end

    task automatic wr_reg(logic [11:0] a, logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; addr = 12'h414; wdata = 0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [7:0] exp);
        @(negedge clk); addr = a; #1;
        check(tag, rdata, exp);
        check({tag, " model"}, rdata, m_read(a));
    endtask

    task automatic set_pin(int n, logic v);
        @(negedge clk); pin[n] = v;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 sense", 12'h404, 8'h00);
        rd_chk("R1 dual", 12'h408, 8'h00);
        rd_chk("R1 pol", 12'h40C, 8'h00);
        rd_chk("R1 en", 12'h410, 8'h00);
        rd_chk("R1 raw", 12'h414, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        // R2 readback
        wr_reg(12'h404, 8'hA5); rd_chk("R2 sense", 12'h404, 8'hA5);
        wr_reg(12'h408, 8'h3C); rd_chk("R2 dual", 12'h408, 8'h3C);
        wr_reg(12'h40C, 8'h5A); rd_chk("R2 pol", 12'h40C, 8'h5A);
        wr_reg(12'h410, 8'h81); rd_chk("R2 en", 12'h410, 8'h81);
        wr_reg(12'h404, 0); wr_reg(12'h408, 0); wr_reg(12'h40C, 0); wr_reg(12'h410, 0);
        wr_reg(12'h41C, 8'hFF);
        rd_chk("R2 raw clean", 12'h414, 8'h00);
        // R3 line0 rising, line1 falling, enable off
        wr_reg(12'h40C, 8'h01);
        set_pin(0, 1); rd_chk("R3 rise latch", 12'h414, 8'h01);
        set_pin(0, 0); rd_chk("R5 held after idle", 12'h414, 8'h01);
        set_pin(1, 1); rd_chk("R3 wrong edge ignored", 12'h414, 8'h01);
        set_pin(1, 0); rd_chk("R3 fall latch", 12'h414, 8'h03);
        check("R5 latched while disabled irq", {7'b0, irq}, 8'h00);
        // R6 clear
        wr_reg(12'h41C, 8'h01); rd_chk("R6 clear line0", 12'h414, 8'h02);
        wr_reg(12'h41C, 8'h00); rd_chk("R6 zero bits no effect", 12'h414, 8'h02);
        rd_chk("R6 clear reads zero", 12'h41C, 8'h00);
        wr_reg(12'h414, 8'hFF); rd_chk("R9 raw write ignored", 12'h414, 8'h02);
        wr_reg(12'h418, 8'hFF); rd_chk("R9 masked write ignored", 12'h410, 8'h00);
        wr_reg(12'h41C, 8'h02); rd_chk("R6 clear line1", 12'h414, 8'h00);
        // R4 dual edge on line2, polarity low
        wr_reg(12'h408, 8'h04);
        set_pin(2, 1); rd_chk("R4 rise in dual", 12'h414, 8'h04);
        wr_reg(12'h41C, 8'h04); rd_chk("R4 cleared", 12'h414, 8'h00);
        set_pin(2, 0); rd_chk("R4 fall in dual", 12'h414, 8'h04);
        wr_reg(12'h41C, 8'h04);
        // R7 clear with simultaneous edge on line0
        set_pin(0, 1); wr_reg(12'h41C, 8'h01);
        set_pin(0, 0); rd_chk("R7 pending", 12'h414, 8'h00);
        @(negedge clk); pin[0] = 1'b1; wr = 1'b1; addr = 12'h41C; wdata = 8'h01;
        @(negedge clk); wr = 1'b0; addr = 12'h414; wdata = 0;
        rd_chk("R7 edge beats clear", 12'h414, 8'h01);
        set_pin(0, 0); wr_reg(12'h41C, 8'h01);
        // R8 level line7 active high
        wr_reg(12'h404, 8'h80); wr_reg(12'h40C, 8'h81);
        set_pin(7, 1); rd_chk("R8 level high", 12'h414, 8'h80);
        wr_reg(12'h41C, 8'h80); rd_chk("R8 clear ignored", 12'h414, 8'h80);
        set_pin(7, 0); rd_chk("R8 level drops", 12'h414, 8'h00);
        wr_reg(12'h40C, 8'h01); rd_chk("R8 active low", 12'h414, 8'h80);
        // R9 / R10 masking
        set_pin(1, 1); set_pin(1, 0);
        rd_chk("R9 raw two lines", 12'h414, 8'h82);
        rd_chk("R9 masked none", 12'h418, 8'h00);
        check("R10 irq off", {7'b0, irq}, 8'h00);
        wr_reg(12'h410, 8'h02);
        rd_chk("R9 masked one", 12'h418, 8'h02);
        check("R10 irq on", {7'b0, irq}, 8'h01);
        wr_reg(12'h41C, 8'h02);
        check("R10 irq off after clear", {7'b0, irq}, 8'h00);
        wr_reg(12'h410, 8'h80);
        check("R10 irq from level", {7'b0, irq}, 8'h01);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule